// File: doc/BRIEF.md
# Branch Decode and Next-PC Unit

This unit sits beside the fetch stage of a 64-bit core whose instructions are fixed 32-bit words. Each cycle it looks at the fetched word and works out what kind of control transfer, if any, the word is. It then produces the address of the next instruction, a taken flag and an optional return-address write. The general register file and the eight condition flags are held outside the block. The unit drives two register read indices straight from the word, without delay, and the two read values come back on data inputs in the same cycle.

All results are captured in output registers with a synchronous, active-high reset. A word presented in one cycle therefore shows its next PC, its flags and its link write after the following rising clock edge. The branch offsets are scattered over the word: the high offset bits sit in the low register-field positions. One conditional form tests a condition flag instead of general registers. The register-indirect jump adds its offset to a register value rather than to the PC.

Top module: `bnpc_unit`

## Requirements
- R1: While `rst` is high, every registered output (`is_branch_o`, `taken_o`, `next_pc_o`, `link_we_o`, `link_idx_o`, `link_data_o`) is zero at the next clock edge.
- R2: A word is a branch only when bits 31:26 lie in 0x10..0x1B, and for 0x12 only when bits 9:8 are 00 or 01. Any other word gives `is_branch_o`=0, `taken_o`=0, `link_we_o`=0 and `next_pc_o` = PC+4.
- R3: Opcode 0x10 is taken when the rj value is zero, and 0x11 when it is nonzero. Their offset is {bits 4:0, bits 25:10, 2'b00}, sign-extended from bit 22. The target is PC plus this offset.
- R4: Opcode 0x12 with bits 9:8 = 00 is taken when condition flag number bits 7:5 is 0. With bits 9:8 = 01 it is taken when that flag is 1. It uses the same offset and target as R3.
- R5: Opcode 0x14 (plain) and 0x15 (with link) are always taken, to PC + sext({bits 9:0, bits 25:10, 2'b00}) from bit 27. Opcode 0x15 also writes PC+4 to register 1.
- R6: Opcode 0x16 is taken when the rj and rd values are equal, and 0x17 when they differ. The target is PC + sext({bits 25:10, 2'b00}) from bit 17.
- R7: Opcodes 0x18 (less than) and 0x19 (greater or equal) compare rj with rd as two's-complement numbers. Opcodes 0x1A and 0x1B make the same two tests on unsigned magnitudes. Offset and target are as in R6.
- R8: Opcode 0x13 is always taken, to the rj value plus the R6 offset. It writes PC+4 to register rd. The target uses the rj value read in the same cycle, so rd equal to rj still jumps through the old value.
- R9: A link write whose destination is register 0 is suppressed (`link_we_o`=0).
- R10: `rj_idx_o` is word bits 9:5 and `rd_idx_o` is bits 4:0, both combinational and without delay.
- R11: A not-taken branch gives `next_pc_o` = PC+4. All registered outputs reflect the inputs of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Fetched instruction word |
| pc_i | input | 64 | Address of the fetched word |
| rj_data_i | input | 64 | Register value read at `rj_idx_o` |
| rd_data_i | input | 64 | Register value read at `rd_idx_o` |
| cflag_i | input | 8 | Condition flag vector |
| rj_idx_o | output | 5 | First register read index |
| rd_idx_o | output | 5 | Second register read index |
| is_branch_o | output | 1 | Word was a branch or jump |
| taken_o | output | 1 | Control transfer taken |
| next_pc_o | output | 64 | Next fetch address |
| link_we_o | output | 1 | Return-address write enable |
| link_idx_o | output | 5 | Return-address destination register |
| link_data_o | output | 64 | Return-address value (PC+4) |

## Verification
The assertions assume that `rj_data_i` and `rd_data_i` arrive in the same cycle as the word and belong to the indices the block drives. They also assume that `pc_i` and `instr_i` hold steady from one falling edge to the next, so that each registered result can be tied to the previous cycle's inputs. The bench changes inputs only on falling edges and returns register values chosen for the indices in that word. Its stimulus covers the opcodes just outside the branch range, all four values of the flag sub-field, rd equal to rj, rd of zero, and operands that differ only in the sign bit.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;

  typedef enum logic [3:0] {
    OP_NONE  = 4'd0,
    OP_BEQZ  = 4'd1,
    OP_BNEZ  = 4'd2,
    OP_BCEQZ = 4'd3,
    OP_BCNEZ = 4'd4,
    OP_JIRL  = 4'd5,
    OP_B     = 4'd6,
    OP_BL    = 4'd7,
    OP_BEQ   = 4'd8,
    OP_BNE   = 4'd9,
    OP_BLT   = 4'd10,
    OP_BGE   = 4'd11,
    OP_BLTU  = 4'd12,
    OP_BGEU  = 4'd13
  } br_op_e;

  localparam int unsigned OFFW_SHORT = 18;  // 16-bit field, word aligned
  localparam int unsigned OFFW_MID   = 23;  // 21-bit field, word aligned
  localparam int unsigned OFFW_LONG  = 28;  // 26-bit field, word aligned
  localparam int unsigned LINK_REG   = 1;   // fixed return register of branch-and-link

endpackage

// File: rtl/bnpc_decode.sv
module bnpc_decode
  import bnpc_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned NFLAG = 8,
  localparam int unsigned CJW  = $clog2(NFLAG)
) (
  input  logic [31:0]      instr_i,
  output br_op_e           op_o,
  output logic [XLEN-1:0]  off_mid_o,
  output logic [XLEN-1:0]  off_long_o,
  output logic [XLEN-1:0]  off_short_o,
  output logic [CJW-1:0]   cj_o
);

  logic [OFFW_MID-1:0]   raw_mid;
  logic [OFFW_LONG-1:0]  raw_long;
  logic [OFFW_SHORT-1:0] raw_short;

  // scattered offset fields: upper bits live in the low register-field slots
  assign raw_mid   = {instr_i[4:0], instr_i[25:10], 2'b00};
  assign raw_long  = {instr_i[9:0], instr_i[25:10], 2'b00};
  assign raw_short = {instr_i[25:10], 2'b00};

  assign off_mid_o   = {{(XLEN-OFFW_MID){raw_mid[OFFW_MID-1]}}, raw_mid};
  assign off_long_o  = {{(XLEN-OFFW_LONG){raw_long[OFFW_LONG-1]}}, raw_long};
  assign off_short_o = {{(XLEN-OFFW_SHORT){raw_short[OFFW_SHORT-1]}}, raw_short};

  assign cj_o = instr_i[5 +: CJW];

  always_comb begin
    unique case (instr_i[31:26])
      6'h10: op_o = OP_BEQZ;
      6'h11: op_o = OP_BNEZ;
      6'h12: begin
        unique case (instr_i[9:8])
          2'b00:   op_o = OP_BCEQZ;
          2'b01:   op_o = OP_BCNEZ;
          default: op_o = OP_NONE;
        endcase
      end
      6'h13: op_o = OP_JIRL;
      6'h14: op_o = OP_B;
      6'h15: op_o = OP_BL;
      6'h16: op_o = OP_BEQ;
      6'h17: op_o = OP_BNE;
      6'h18: op_o = OP_BLT;
      6'h19: op_o = OP_BGE;
      6'h1A: op_o = OP_BLTU;
      6'h1B: op_o = OP_BGEU;
      default: op_o = OP_NONE;
    endcase
  end

endmodule

// File: rtl/bnpc_cond.sv
module bnpc_cond
  import bnpc_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned NFLAG = 8,
  localparam int unsigned CJW  = $clog2(NFLAG)
) (
  input  br_op_e           op_i,
  input  logic [XLEN-1:0]  rj_data_i,
  input  logic [XLEN-1:0]  rd_data_i,
  input  logic [NFLAG-1:0] cflag_i,
  input  logic [CJW-1:0]   cj_i,
  output logic             taken_o
);

  logic rj_zero, eq, lt_s, lt_u, flag;

  assign rj_zero = (rj_data_i == '0);
  assign eq      = (rj_data_i == rd_data_i);
  assign lt_s    = ($signed(rj_data_i) < $signed(rd_data_i));
  assign lt_u    = (rj_data_i < rd_data_i);
  assign flag    = cflag_i[cj_i];

  always_comb begin
    unique case (op_i)
      OP_BEQZ:  taken_o = rj_zero;
      OP_BNEZ:  taken_o = !rj_zero;
      OP_BCEQZ: taken_o = !flag;
      OP_BCNEZ: taken_o = flag;
      OP_JIRL,
      OP_B,
      OP_BL:    taken_o = 1'b1;
      OP_BEQ:   taken_o = eq;
      OP_BNE:   taken_o = !eq;
      OP_BLT:   taken_o = lt_s;
      OP_BGE:   taken_o = !lt_s;
      OP_BLTU:  taken_o = lt_u;
      OP_BGEU:  taken_o = !lt_u;
      default:  taken_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/bnpc_target.sv
module bnpc_target
  import bnpc_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned RIW  = 5
) (
  input  br_op_e           op_i,
  input  logic             taken_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  rj_data_i,
  input  logic [RIW-1:0]   rd_idx_i,
  input  logic [XLEN-1:0]  off_mid_i,
  input  logic [XLEN-1:0]  off_long_i,
  input  logic [XLEN-1:0]  off_short_i,
  output logic [XLEN-1:0]  next_pc_o,
  output logic             link_we_o,
  output logic [RIW-1:0]   link_idx_o,
  output logic [XLEN-1:0]  link_data_o
);

  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] seq_pc, base, offset, target;

  assign seq_pc = pc_i + STEP;

  always_comb begin
    unique case (op_i)
      OP_BEQZ, OP_BNEZ, OP_BCEQZ, OP_BCNEZ: offset = off_mid_i;
      OP_B, OP_BL:                          offset = off_long_i;
      default:                              offset = off_short_i;
    endcase
  end

  // indirect jump bases on the register value sampled this cycle
  assign base      = (op_i == OP_JIRL) ? rj_data_i : pc_i;
  assign target    = base + offset;
  assign next_pc_o = taken_i ? target : seq_pc;

  always_comb begin
    link_we_o  = 1'b0;
    link_idx_o = '0;
    if (op_i == OP_BL) begin
      link_idx_o = RIW'(LINK_REG);
      link_we_o  = 1'b1;
    end else if (op_i == OP_JIRL) begin
      link_idx_o = rd_idx_i;
      link_we_o  = (rd_idx_i != '0);
    end
  end

  assign link_data_o = seq_pc;

endmodule

// File: rtl/bnpc_unit.sv
module bnpc_unit
  import bnpc_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned NFLAG = 8,
  parameter int unsigned RIW   = 5,
  localparam int unsigned CJW  = $clog2(NFLAG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [31:0]      instr_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  rj_data_i,
  input  logic [XLEN-1:0]  rd_data_i,
  input  logic [NFLAG-1:0] cflag_i,
  output logic [RIW-1:0]   rj_idx_o,
  output logic [RIW-1:0]   rd_idx_o,
  output logic             is_branch_o,
  output logic             taken_o,
  output logic [XLEN-1:0]  next_pc_o,
  output logic             link_we_o,
  output logic [RIW-1:0]   link_idx_o,
  output logic [XLEN-1:0]  link_data_o
);

  br_op_e           op;
  logic [XLEN-1:0]  off_mid, off_long, off_short;
  logic [CJW-1:0]   cj;
  logic             taken_d, link_we_d;
  logic [XLEN-1:0]  next_pc_d, link_data_d;
  logic [RIW-1:0]   link_idx_d;
  logic             primed_q;

  assign rj_idx_o = instr_i[5 +: RIW];
  assign rd_idx_o = instr_i[0 +: RIW];

  bnpc_decode #(.XLEN(XLEN), .NFLAG(NFLAG)) u_decode (
    .instr_i     (instr_i),
    .op_o        (op),
    .off_mid_o   (off_mid),
    .off_long_o  (off_long),
    .off_short_o (off_short),
    .cj_o        (cj)
  );

  bnpc_cond #(.XLEN(XLEN), .NFLAG(NFLAG)) u_cond (
    .op_i      (op),
    .rj_data_i (rj_data_i),
    .rd_data_i (rd_data_i),
    .cflag_i   (cflag_i),
    .cj_i      (cj),
    .taken_o   (taken_d)
  );

  bnpc_target #(.XLEN(XLEN), .RIW(RIW)) u_target (
    .op_i        (op),
    .taken_i     (taken_d),
    .pc_i        (pc_i),
    .rj_data_i   (rj_data_i),
    .rd_idx_i    (rd_idx_o),
    .off_mid_i   (off_mid),
    .off_long_i  (off_long),
    .off_short_i (off_short),
    .next_pc_o   (next_pc_d),
    .link_we_o   (link_we_d),
    .link_idx_o  (link_idx_d),
    .link_data_o (link_data_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      is_branch_o <= 1'b0;
      taken_o     <= 1'b0;
      next_pc_o   <= '0;
      link_we_o   <= 1'b0;
      link_idx_o  <= '0;
      link_data_o <= '0;
      primed_q    <= 1'b0;
    end else begin
      is_branch_o <= (op != OP_NONE);
      taken_o     <= taken_d;
      next_pc_o   <= next_pc_d;
      link_we_o   <= link_we_d;
      link_idx_o  <= link_idx_d;
      link_data_o <= link_data_d;
      primed_q    <= 1'b1;
    end
  end

  // non-branch words fall through to the sequential address
  p_nonbranch_seq_r2: assert property (@(posedge clk) disable iff (rst)
    (primed_q && !is_branch_o) |->
      (next_pc_o == $past(pc_i) + XLEN'(4) && !taken_o && !link_we_o));

  p_taken_is_branch_r2: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> is_branch_o);

  // not-taken branch falls through
  p_not_taken_seq_r11: assert property (@(posedge clk) disable iff (rst)
    (primed_q && is_branch_o && !taken_o) |-> (next_pc_o == $past(pc_i) + XLEN'(4)));

  p_bl_links_r1_r5: assert property (@(posedge clk) disable iff (rst)
    (primed_q && $past(instr_i[31:26]) == 6'h15) |->
      (taken_o && link_we_o && link_idx_o == RIW'(LINK_REG)
       && link_data_o == $past(pc_i) + XLEN'(4)));

  p_no_r0_link_r9: assert property (@(posedge clk) disable iff (rst)
    link_we_o |-> (link_idx_o != '0));

  p_jirl_target_r8: assert property (@(posedge clk) disable iff (rst)
    (primed_q && $past(instr_i[31:26]) == 6'h13) |->
      (taken_o && next_pc_o == $past(rj_data_i) + $past(off_short)));

endmodule

// File: tb/bnpc_unit_tb_top.sv
module bnpc_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] instr;
  logic [63:0] pc, rjv, rdv;
  logic [7:0]  fl;
  logic [4:0]  rj_idx, rd_idx, link_idx;
  logic        is_br, taken, link_we;
  logic [63:0] next_pc, link_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bnpc_unit dut_i (
    .clk(clk), .rst(rst), .instr_i(instr), .pc_i(pc), .rj_data_i(rjv),
    .rd_data_i(rdv), .cflag_i(fl), .rj_idx_o(rj_idx), .rd_idx_o(rd_idx),
    .is_branch_o(is_br), .taken_o(taken), .next_pc_o(next_pc),
    .link_we_o(link_we), .link_idx_o(link_idx), .link_data_o(link_data)
  );

  // expected state for the word presented last cycle
  logic        e_br, e_tk, e_lwe;
  logic [63:0] e_npc, e_ldata;
  logic [4:0]  e_lidx;
  string       e_tag;

  task automatic model();
    logic [63:0] o16, o21, o26, seq, tgt;
    int op;
    op  = int'(instr[31:26]);
    o16 = {{46{instr[25]}}, instr[25:10], 2'b00};
    o21 = {{41{instr[4]}}, instr[4:0], instr[25:10], 2'b00};
    o26 = {{36{instr[9]}}, instr[9:0], instr[25:10], 2'b00};
    seq = pc + 64'd4;
    tgt = seq;
    e_br = 1; e_tk = 0; e_lwe = 0; e_lidx = 0; e_ldata = seq; e_tag = "R2";
    case (op)
      16: begin e_tk = (rjv == 0); tgt = pc + o21; e_tag = "R3"; end
      17: begin e_tk = (rjv != 0); tgt = pc + o21; e_tag = "R3"; end
      18: begin
        tgt = pc + o21; e_tag = "R4";
        if (instr[9:8] == 2'b00) e_tk = (fl[instr[7:5]] == 1'b0);
        else if (instr[9:8] == 2'b01) e_tk = (fl[instr[7:5]] == 1'b1);
        else begin e_br = 0; e_tag = "R2"; end
      end
      19: begin
        e_tk = 1; tgt = rjv + o16; e_lidx = instr[4:0]; e_lwe = (instr[4:0] != 0);
        e_tag = (instr[4:0] == 0) ? "R9" : "R8";
      end
      20: begin e_tk = 1; tgt = pc + o26; e_tag = "R5"; end
      21: begin e_tk = 1; tgt = pc + o26; e_lwe = 1; e_lidx = 5'd1; e_tag = "R5"; end
      22: begin e_tk = (rjv == rdv); tgt = pc + o16; e_tag = "R6"; end
      23: begin e_tk = (rjv != rdv); tgt = pc + o16; e_tag = "R6"; end
      24: begin e_tk = ($signed(rjv) < $signed(rdv)); tgt = pc + o16; e_tag = "R7"; end
      25: begin e_tk = ($signed(rjv) >= $signed(rdv)); tgt = pc + o16; e_tag = "R7"; end
      26: begin e_tk = (rjv < rdv); tgt = pc + o16; e_tag = "R7"; end
      27: begin e_tk = (rjv >= rdv); tgt = pc + o16; e_tag = "R7"; end
      default: e_br = 0;
    endcase
    if (e_br && !e_tk && e_tag != "R2") e_tag = {e_tag, "/R11"};
    e_npc = e_tk ? tgt : seq;
    if (!e_br) begin e_lwe = 0; e_lidx = 0; end
  endtask

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s instr=%h actual=%h expected=%h", tag, instr, act, exp);
    end
  endtask

  // drive at a falling edge, compare at the next falling edge
  task automatic apply(input logic [31:0] w, input logic [63:0] p,
                       input logic [63:0] a, input logic [63:0] b, input logic [7:0] f);
    instr = w; pc = p; rjv = a; rdv = b; fl = f;
    #1;
    check("R10", {246'd0, rj_idx, rd_idx}, {246'd0, w[9:5], w[4:0]});
    model();
    @(negedge clk);
    check(e_tag, {57'd0, is_br, taken, link_we, link_idx, next_pc, link_data},
                 {57'd0, e_br, e_tk, e_lwe, e_lidx, e_npc, e_ldata});
  endtask

  function automatic logic [31:0] w21(input logic [5:0] op, input logic [4:0] rj, input logic [20:0] off);
    return {op, off[15:0], rj, off[20:16]};
  endfunction
  function automatic logic [31:0] wflag(input logic [1:0] sub, input logic [2:0] cj, input logic [20:0] off);
    return {6'h12, off[15:0], sub, cj, off[20:16]};
  endfunction
  function automatic logic [31:0] w26(input logic [5:0] op, input logic [25:0] off);
    return {op, off[15:0], off[25:16]};
  endfunction
  function automatic logic [31:0] w16(input logic [5:0] op, input logic [15:0] off,
                                      input logic [4:0] rj, input logic [4:0] rd);
    return {op, off, rj, rd};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; instr = 32'h1234_5678; pc = 64'hFFFF; rjv = '1; rdv = '1; fl = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: registered outputs cleared under reset
    check("R1", {57'd0, is_br, taken, link_we, link_idx, next_pc, link_data}, 256'd0);
    rst = 0;
    // R3 zero/nonzero, taken and not, negative and max offsets
    apply(w21(6'h10, 5'd3, 21'h1FFFFF), 64'h1000, 64'd0, 64'd5, 8'h00);
    apply(w21(6'h10, 5'd3, 21'h0FFFFF), 64'h1000, 64'd1, 64'd5, 8'h00);
    apply(w21(6'h11, 5'd7, 21'h100000), 64'h8000_0000, 64'd9, 64'd0, 8'h00);
    apply(w21(6'h11, 5'd7, 21'h000010), 64'h8000_0000, 64'd0, 64'd0, 8'h00);
    // R4 flag branches, all sub-field values
    apply(wflag(2'b00, 3'd5, 21'h000020), 64'h2000, 64'd0, 64'd0, 8'b1101_1111);
    apply(wflag(2'b00, 3'd4, 21'h000020), 64'h2000, 64'd0, 64'd0, 8'b1101_1111);
    apply(wflag(2'b01, 3'd7, 21'h1FFFF0), 64'h2000, 64'd0, 64'd0, 8'b1000_0000);
    apply(wflag(2'b01, 3'd0, 21'h1FFFF0), 64'h2000, 64'd0, 64'd0, 8'b1000_0000);
    apply(wflag(2'b10, 3'd0, 21'h000004), 64'h2000, 64'd0, 64'd0, 8'h00);
    apply(wflag(2'b11, 3'd0, 21'h000004), 64'h2000, 64'd0, 64'd0, 8'hFF);
    // R5 long branches, extremes of the 26-bit field
    apply(w26(6'h14, 26'h2000000), 64'h1_0000_0000, 64'd0, 64'd0, 8'h00);
    apply(w26(6'h15, 26'h1FFFFFF), 64'h4000, 64'd0, 64'd0, 8'h00);
    // R8 indirect jump with rd == rj, R9 with rd == 0
    apply(w16(6'h13, 16'hFFFF, 5'd4, 5'd4), 64'h3000, 64'h9000, 64'd0, 8'h00);
    apply(w16(6'h13, 16'h0010, 5'd4, 5'd0), 64'h3000, 64'h9000, 64'd0, 8'h00);
    // R6 equality
    apply(w16(6'h16, 16'h8000, 5'd1, 5'd2), 64'h40000, 64'd77, 64'd77, 8'h00);
    apply(w16(6'h17, 16'h8000, 5'd1, 5'd2), 64'h40000, 64'd77, 64'd77, 8'h00);
    // R7 signed vs unsigned on sign-bit differences, equality edge
    apply(w16(6'h18, 16'h0004, 5'd1, 5'd2), 64'h100, 64'h8000_0000_0000_0000, 64'd1, 8'h00);
    apply(w16(6'h1A, 16'h0004, 5'd1, 5'd2), 64'h100, 64'h8000_0000_0000_0000, 64'd1, 8'h00);
    apply(w16(6'h19, 16'h0004, 5'd1, 5'd2), 64'h100, 64'd5, 64'd5, 8'h00);
    apply(w16(6'h1B, 16'h0004, 5'd1, 5'd2), 64'h100, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00);
    // R2 neighbours of the branch range
    apply(32'h3FFF_FFFF, 64'h500, 64'd0, 64'd0, 8'h00);
    apply(32'h7000_0000, 64'h500, 64'd0, 64'd0, 8'h00);
    // random sweep around the branch opcodes
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w;
      logic [63:0] a, b;
      w = $urandom;
      w[31:26] = 6'(14 + ($urandom % 16));
      a = {$urandom, $urandom};
      b = ($urandom % 4 == 0) ? a : {$urandom, $urandom};
      if ($urandom % 4 == 0) a = 64'd0;
      apply(w, {$urandom, $urandom[31:2], 2'b00}, a, b, 8'($urandom));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule